// File: doc/BRIEF.md
# Receive Sample Saturator with Sticky Clip Flag

This block sits at the end of a receive datapath. It accepts a signed internal sample that is wider than the output word, so the sample has headroom above full scale. The block limits that sample to the range of the selected output format and registers the 16-bit result. The output is a two's complement word with either one sign bit or two repeated sign bits.

Whenever a valid sample has to be limited, a clip flag rises and stays high. Later in-range samples do not lower it. Only an explicit clear pulse lowers the flag. The clear pulse represents a control write of zero to the clip-clear field, and it comes from the register decoder. If a new saturation arrives in the same cycle as a clear, the saturation wins.

Top module: `rx_clip_sat`

## Requirements
- R1: While `rst` is high at a clock edge, `out_word` becomes 0x0000 and `clip` becomes 0.
- R2: With `fmt_one_sign` = 1, a valid sample greater than +32767 gives `out_word` = 0x7FFF.
- R3: With `fmt_one_sign` = 1, a valid sample less than -32768 gives `out_word` = 0x8000.
- R4: With `fmt_one_sign` = 0, a valid sample greater than +16383 gives `out_word` = 0x3FFF.
- R5: With `fmt_one_sign` = 0, a valid sample less than -16384 gives `out_word` = 0xC000.
- R6: A valid sample inside the selected range is passed through unchanged as its low 16 bits. This includes the exact limits, and such a sample does not set `clip`.
- R7: `out_word` updates on the clock edge at which `in_valid` is high. With `in_valid` low, the edge leaves `out_word` unchanged.
- R8: A valid sample that saturates sets `clip` at that same edge. Later in-range samples and idle cycles leave it high.
- R9: A `clr_clip` pulse with no saturating sample in the same cycle drives `clip` to 0 at that edge.
- R10: When `clr_clip` and a saturating valid sample occur in the same cycle, `clip` is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 18 | Signed internal sample with headroom |
| fmt_one_sign | input | 1 | 1: one sign bit, 0: two sign bits |
| clr_clip | input | 1 | Clear request for the clip flag |
| out_word | output | 16 | Registered saturated word |
| clip | output | 1 | Sticky saturation flag |

## Verification
A wrong limit selection shows up on `out_word` one edge after the offending sample. It appears as a value outside the format range, or as an in-range value that was altered. A corrupted flag state also shows one edge later. Examples are a flag lost on an idle cycle, a flag that stays set after a clear, or a clear that beats a simultaneous clip. The scoreboard checks both outputs after every driven cycle, so any such error is reported on the cycle it first appears.

// File: rtl/rxsat_pkg.sv
package rxsat_pkg;
    localparam int SAMPLE_W = 18;
    localparam int WORD_W   = 16;

    typedef enum logic {
        FMT_TWO_SIGN = 1'b0,
        FMT_ONE_SIGN = 1'b1
    } fmt_e;

    typedef struct packed {
        logic over;
        logic under;
    } sat_hit_t;

    function automatic logic any_hit(input sat_hit_t h);
        return h.over | h.under;
    endfunction
endpackage

// File: rtl/rxsat_core.sv
module rxsat_core
    import rxsat_pkg::*;
#(
    parameter int IN_W  = SAMPLE_W,
    parameter int OUT_W = WORD_W
) (
    input  logic signed [IN_W-1:0]  sample,
    input  fmt_e                    fmt,
    output logic        [OUT_W-1:0] word,
    output sat_hit_t                hit
);
    localparam int HI_ONE = (1 << (OUT_W - 1)) - 1;
    localparam int LO_ONE = -(1 << (OUT_W - 1));
    localparam int HI_TWO = (1 << (OUT_W - 2)) - 1;
    localparam int LO_TWO = -(1 << (OUT_W - 2));

    logic signed [IN_W-1:0] lim_hi;
    logic signed [IN_W-1:0] lim_lo;

    always_comb begin
        if (fmt == FMT_ONE_SIGN) begin
            lim_hi = IN_W'(HI_ONE);
            lim_lo = IN_W'(LO_ONE);
        end else begin
            lim_hi = IN_W'(HI_TWO);
            lim_lo = IN_W'(LO_TWO);
        end
        hit.over  = sample > lim_hi;
        hit.under = sample < lim_lo;
        if (hit.over)       word = lim_hi[OUT_W-1:0];
        else if (hit.under) word = lim_lo[OUT_W-1:0];
        else                word = sample[OUT_W-1:0];
    end
endmodule

// File: rtl/rxsat_flag.sv
module rxsat_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr_ev) flag <= 1'b0;
    end
endmodule

// File: rtl/rx_clip_sat.sv
module rx_clip_sat
    import rxsat_pkg::*;
#(
    parameter int IN_W  = SAMPLE_W,
    parameter int OUT_W = WORD_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_sample,
    input  logic                    fmt_one_sign,
    input  logic                    clr_clip,
    output logic        [OUT_W-1:0] out_word,
    output logic                    clip
);
    fmt_e               fmt;
    logic [OUT_W-1:0]   sat_word;
    sat_hit_t           sat_hit;
    logic               sat_ev;

    assign fmt    = fmt_one_sign ? FMT_ONE_SIGN : FMT_TWO_SIGN;
    assign sat_ev = in_valid & any_hit(sat_hit);

    rxsat_core #(.IN_W(IN_W), .OUT_W(OUT_W)) u_core (
        .sample (in_sample),
        .fmt    (fmt),
        .word   (sat_word),
        .hit    (sat_hit)
    );

    rxsat_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_ev (sat_ev),
        .clr_ev (clr_clip),
        .flag   (clip)
    );

    always_ff @(posedge clk) begin
        if (rst)           out_word <= '0;
        else if (in_valid) out_word <= sat_word;
    end
endmodule

// File: rtl/rx_clip_sat_chk.sv
module rx_clip_sat_chk #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic signed [IN_W-1:0]  in_sample,
    input logic                    fmt_one_sign,
    input logic                    clr_clip,
    input logic        [OUT_W-1:0] out_word,
    input logic                    clip
);
    localparam int TOP1 = (1 << (OUT_W - 1)) - 1;
    localparam int TOP2 = (1 << (OUT_W - 2)) - 1;

    logic signed [IN_W-1:0] c_hi;
    logic signed [IN_W-1:0] c_lo;
    logic                   oor;

    assign c_hi = fmt_one_sign ? IN_W'(TOP1) : IN_W'(TOP2);
    assign c_lo = ~c_hi;
    assign oor  = (in_sample > c_hi) || (in_sample < c_lo);

    assert_two_sign_range_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fmt_one_sign) |=> (out_word[OUT_W-1] == out_word[OUT_W-2]));

    assert_pass_through_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !oor) |=> (out_word == $past(in_sample[OUT_W-1:0])));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));

    assert_clip_set_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && oor) |=> clip);

    assert_clip_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (clip && !clr_clip) |=> clip);

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_clip && !(in_valid && oor)) |=> !clip);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        (!clip && !(in_valid && oor)) |=> !clip);
endmodule

bind rx_clip_sat rx_clip_sat_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_sample    (in_sample),
    .fmt_one_sign (fmt_one_sign),
    .clr_clip     (clr_clip),
    .out_word     (out_word),
    .clip         (clip)
);

// File: tb/tb_rx_clip_sat.sv
`timescale 1ns/1ps
module tb_rx_clip_sat;
    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic signed [17:0] in_sample;
    logic               fmt_one_sign;
    logic               clr_clip;
    logic [15:0]        out_word;
    logic               clip;

    typedef struct {
        logic [15:0] word;
        logic        flag;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] m_word  = 16'h0000;
    logic        m_flag  = 1'b0;
    bit          done    = 1'b0;

    always #4 clk = ~clk;

    rx_clip_sat dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .fmt_one_sign(fmt_one_sign), .clr_clip(clr_clip),
        .out_word(out_word), .clip(clip)
    );

    task automatic check(input string req, input logic [15:0] aw, input logic [15:0] ew,
                         input logic af, input logic ef);
        n_tests++;
        if (aw !== ew || af !== ef) begin
            n_fail++;
            $display("FAIL %s: word=%h flag=%b expected word=%h flag=%b", req, aw, af, ew, ef);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic drive(input bit v, input int s, input bit one, input bit clr, input string req);
        int  hi, lo;
        bit  sat;
        exp_t e;
        @(negedge clk);
        in_valid = v; in_sample = 18'(s); fmt_one_sign = one; clr_clip = clr;
        hi  = one ? 32767 : 16383;
        lo  = one ? -32768 : -16384;
        sat = v && (s > hi || s < lo);
        if (v) m_word = (s > hi) ? 16'(hi) : (s < lo) ? 16'(lo) : 16'(s);
        if (sat)      m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        e.word = m_word; e.flag = m_flag; e.req = req;
        sb_q.push_back(e);
    endtask

    // monitor: compares after the edge that consumed the stimulus
    always @(posedge clk) begin
        #2;
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, out_word, e.word, clip, e.flag);
        end
    end

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog: word=%h flag=%b expected completion", out_word, clip);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_sample = '0; fmt_one_sign = 1'b1; clr_clip = 1'b0;
        repeat (3) @(posedge clk);
        #2 check("R1", out_word, 16'h0000, clip, 1'b0);
        @(negedge clk); rst = 1'b0;

        drive(1, 32'h1234, 1, 0, "R6");
        drive(1, 32767,    1, 0, "R6");
        drive(1, -32768,   1, 0, "R6");
        drive(1, 40000,    1, 0, "R2");
        drive(0, 5,        1, 0, "R7");
        drive(1, 100,      1, 0, "R8");
        drive(0, 0,        1, 1, "R9");
        drive(1, -40000,   1, 0, "R3");
        drive(1, 20000,    0, 1, "R10");
        drive(0, 0,        0, 1, "R9");
        drive(1, -20000,   0, 0, "R5");
        drive(1, 7,        0, 1, "R9");
        drive(1, 16383,    0, 0, "R6");
        drive(1, -16384,   0, 0, "R6");
        drive(1, 32'h1000, 0, 0, "R6");
        drive(1, 16384,    0, 0, "R4");
        drive(1, -1,       0, 0, "R8");
        drive(1, -131072,  0, 1, "R10");
        drive(0, 0,        0, 1, "R9");
        drive(1, 131071,   1, 0, "R2");
        drive(0, -200,     0, 0, "R7");
        drive(1, -32769,   1, 1, "R3");
        drive(0, 0,        1, 1, "R9");
        drive(0, 0,        1, 0, "R7");

        @(negedge clk);
        in_valid = 1'b0; clr_clip = 1'b0;
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1", out_word, 16'h0000, clip, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule